// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives the system reset line of a microcontroller. It combines two sources: a digital supply-good flag from an analog comparator and a watchdog that watches the serial chip-select line. The block raises reset when power is applied and whenever the supply flag drops. It lowers reset only after the flag has stayed high for a fixed release delay.

The watchdog counts clock cycles from the last high-to-low transition of chip select. If the line stays at either level for longer than the selected period, the watchdog raises reset. That reset lasts for the same release delay as a power-on reset, and the watchdog then starts counting again from zero. The period comes from a 2-bit selector that a nonvolatile status register supplies. The block treats the selector as a live input and never clears it. All delays are clock-cycle parameters.

Top module: `rsv_top`

## Requirements
- R1: While `rst` is high, `sys_rst` is high, and it is still high in the cycle after `rst` falls.
- R2: After a reset, `sys_rst` falls right after the clock edge that is the `RELEASE_CYC`-th consecutive edge sampling `supply_ok` high. It is still high after the edge before that one.
- R3: `sys_rst` goes high in the same cycle that `supply_ok` is low, with no clock edge needed. It stays high for as long as `supply_ok` is low.
- R4: Every cycle in which `supply_ok` is sampled low clears the release count. After a one-cycle glitch, the full `RELEASE_CYC` edges are needed again.
- R5: A chip-select falling edge restarts the watchdog count. A falling edge is `cs_n` sampled 1 at one edge and 0 at the next. The next trip comes only after a full period counted from the edge that saw the kick.
- R6: With `cs_n` held at either level, the watchdog raises `sys_rst` after the period-th edge counted from release or from the last kick. A rising edge of `cs_n` does not restart the count.
- R7: The `wd_sel` codes give these periods: 2'b00 gives `WD_LONG_CYC`, 2'b01 gives `WD_MID_CYC` and 2'b10 gives `WD_SHORT_CYC`.
- R8: `wd_sel` = 2'b11 disables the watchdog, and `sys_rst` then never rises from it however long `cs_n` is idle.
- R9: After a watchdog trip, `sys_rst` stays high for exactly `RELEASE_CYC` edges. The watchdog then counts a fresh full period from zero.
- R10: If `wd_sel` is switched to a period shorter than the count already elapsed, the watchdog trips at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok | input | 1 | High while the supply is above its threshold |
| cs_n | input | 1 | Serial chip select, used as the watchdog kick |
| wd_sel | input | 2 | Watchdog period selector from the persistent status bits |
| sys_rst | output | 1 | Active-high system reset |

## Verification
The hardest cases to reach are the ones where the watchdog count sits above a newly selected, shorter period, and where a trip starts a second full period. The bench first holds the watchdog off with code 2'b11 so that its count is known to be zero. It then enables a period and counts edges exactly. For R10 it lets the long period run 45 cycles and switches to the short code. For R9 it waits through the release after a trip and times a second trip.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Watchdog period codes; the 2-bit value is what the status bits carry
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Reset phase of the release timer
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    // Events passed from the watchdog path to the top
    typedef struct packed {
        logic kick;
        logic trip;
    } wd_evt_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rsv_kick_detect.sv
module rsv_kick_detect (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic kick
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs_n;
    end

    // high-to-low transition between two samples
    assign kick = cs_q & ~cs_n;

    // R5: a kick is only seen when the line is low afterwards
    a_r5_kick_then_low: assert property (@(posedge clk) disable iff (rst)
        kick |=> !cs_q);

endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog
    import rsv_pkg::*;
#(
    parameter int unsigned WD_LONG_CYC  = 175_000_000,
    parameter int unsigned WD_MID_CYC   = 75_000_000,
    parameter int unsigned WD_SHORT_CYC = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    output logic       trip
);
    localparam int unsigned TMAX = max3(WD_LONG_CYC, WD_MID_CYC, WD_SHORT_CYC);
    localparam int CW = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_m1;
    logic          enabled;
    wd_sel_e       sel;

    assign sel = wd_sel_e'(wd_sel);

    always_comb begin
        enabled  = 1'b1;
        limit_m1 = '0;
        case (sel)
            WD_LONG:  limit_m1 = CW'(WD_LONG_CYC - 1);
            WD_MID:   limit_m1 = CW'(WD_MID_CYC - 1);
            WD_SHORT: limit_m1 = CW'(WD_SHORT_CYC - 1);
            default:  enabled  = 1'b0;
        endcase
    end

    // >= so that a shortened period fires at once
    assign trip = enabled & ~hold & ~kick & (cnt >= limit_m1);

    always_ff @(posedge clk) begin
        if (rst || hold || !enabled || kick || trip) cnt <= '0;
        else                                         cnt <= cnt + 1'b1;
    end

    // R8: disabled code never trips
    a_r8_off_no_trip: assert property (@(posedge clk) disable iff (rst)
        (wd_sel == 2'b11) |-> !trip);

    // R5: kick clears the count
    a_r5_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0));

    // R6: count never runs past the longest period
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TMAX - 1));

    // R9: count restarts from zero while reset is held
    a_r9_zero_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0));

endmodule

// File: rtl/rsv_release_timer.sv
module rsv_release_timer
    import rsv_pkg::*;
#(
    parameter int unsigned RELEASE_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic trip,
    output logic hold
);
    localparam int RW = $clog2(RELEASE_CYC + 1);

    phase_e        phase;
    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (!supply_ok || trip) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (phase == PH_HOLD) begin
            if (cnt == RW'(RELEASE_CYC - 1)) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hold = (phase == PH_HOLD);

    // R1: power-on reset forces the hold phase
    a_r1_reset_holds: assert property (@(posedge clk)
        rst |=> hold);

    // R4: a low supply sample clears the release count
    a_r4_low_clears: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (hold && cnt == '0));

    // R9: a watchdog trip enters the hold phase
    a_r9_trip_holds: assert property (@(posedge clk) disable iff (rst)
        trip |=> hold);

    // R2: release only follows a good supply sample
    a_r2_release_on_ok: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> $past(supply_ok));

endmodule

// File: rtl/rsv_top.sv
module rsv_top
    import rsv_pkg::*;
#(
    parameter int unsigned RELEASE_CYC  = 25_000_000,
    parameter int unsigned WD_LONG_CYC  = 175_000_000,
    parameter int unsigned WD_MID_CYC   = 75_000_000,
    parameter int unsigned WD_SHORT_CYC = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       cs_n,
    input  logic [1:0] wd_sel,
    output logic       sys_rst
);
    wd_evt_t evt;
    logic    hold;

    rsv_kick_detect u_kick (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .kick (evt.kick)
    );

    rsv_watchdog #(
        .WD_LONG_CYC  (WD_LONG_CYC),
        .WD_MID_CYC   (WD_MID_CYC),
        .WD_SHORT_CYC (WD_SHORT_CYC)
    ) u_wd (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .kick   (evt.kick),
        .wd_sel (wd_sel),
        .trip   (evt.trip)
    );

    rsv_release_timer #(
        .RELEASE_CYC (RELEASE_CYC)
    ) u_rel (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .trip      (evt.trip),
        .hold      (hold)
    );

    // supply loss reaches the output without waiting for a clock edge
    assign sys_rst = hold | ~supply_ok;

    // R3: a low supply keeps reset up on the following cycle
    a_r3_low_keeps_rst: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> sys_rst);

endmodule

// File: tb/rsv_top_test.sv
`timescale 1ns/1ps
module rsv_top_test;
    localparam int REL   = 20;
    localparam int TLONG = 60;
    localparam int TMID  = 40;
    localparam int TSHRT = 25;

    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok;
    logic       cs_n;
    logic [1:0] wd_sel;
    logic       sys_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rsv_top #(
        .RELEASE_CYC  (REL),
        .WD_LONG_CYC  (TLONG),
        .WD_MID_CYC   (TMID),
        .WD_SHORT_CYC (TSHRT)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .cs_n      (cs_n),
        .wd_sel    (wd_sel),
        .sys_rst   (sys_rst)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sys_rst=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // R1, R2, R3: power-on sequence
    task automatic t_powerup;
        rst = 1'b1; supply_ok = 1'b0; cs_n = 1'b1; wd_sel = 2'b11;
        step(3);
        chk("R1 in reset", sys_rst, 1'b1);
        supply_ok = 1'b1;
        step(2);
        chk("R1 reset with supply ok", sys_rst, 1'b1);
        rst = 1'b0; supply_ok = 1'b0;
        step(4);
        chk("R3 supply low after reset", sys_rst, 1'b1);
        supply_ok = 1'b1;
        step(REL - 1);
        chk("R2 one edge before release", sys_rst, 1'b1);
        step(1);
        chk("R2 release edge", sys_rst, 1'b0);
    endtask

    // R3, R4: brownout
    task automatic t_brownout;
        supply_ok = 1'b0;
        #1;
        chk("R3 immediate assert", sys_rst, 1'b1);
        step(3);
        chk("R3 held while low", sys_rst, 1'b1);
        supply_ok = 1'b1;
        step(REL - 1);
        chk("R4 full delay after brownout, early", sys_rst, 1'b1);
        step(1);
        chk("R4 full delay after brownout, release", sys_rst, 1'b0);
    endtask

    // R4: glitch during release count
    task automatic t_glitch;
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(12);
        chk("R4 mid count", sys_rst, 1'b1);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(REL - 1);
        chk("R4 glitch restarts delay", sys_rst, 1'b1);
        step(1);
        chk("R4 release after glitch", sys_rst, 1'b0);
    endtask

    // R6, R7, R9: stuck line at a given code
    task automatic t_timeout(input logic [1:0] code, input int per, input logic lvl);
        cs_n = lvl;
        step(1);
        wd_sel = code;
        step(per - 1);
        chk("R7 before period end", sys_rst, 1'b0);
        step(1);
        chk("R6 R7 trip at period", sys_rst, 1'b1);
        step(REL - 1);
        chk("R9 held after trip", sys_rst, 1'b1);
        step(1);
        chk("R9 release after trip", sys_rst, 1'b0);
        step(per - 1);
        chk("R9 fresh period, early", sys_rst, 1'b0);
        step(1);
        chk("R9 second trip", sys_rst, 1'b1);
        wd_sel = 2'b11;
        step(REL);
        chk("R9 release with watchdog off", sys_rst, 1'b0);
    endtask

    // R5, R6: kick restarts, rising edge does not
    task automatic t_kick;
        cs_n = 1'b1;
        step(1);
        wd_sel = 2'b10;
        step(20);
        cs_n = 1'b0;
        step(1);
        step(10);
        cs_n = 1'b1;
        step(TSHRT - 11);
        chk("R5 R6 kick restarted, rise ignored", sys_rst, 1'b0);
        step(1);
        chk("R5 trip a full period after kick", sys_rst, 1'b1);
        wd_sel = 2'b11;
        step(REL);
        chk("R5 recovered", sys_rst, 1'b0);
    endtask

    // R8: disabled watchdog
    task automatic t_disabled;
        logic seen;
        seen = 1'b0;
        wd_sel = 2'b11;
        cs_n = 1'b0;
        for (int i = 0; i < 200; i++) begin
            step(1);
            seen = seen | sys_rst;
        end
        chk("R8 off never trips", seen, 1'b0);
        cs_n = 1'b1;
    endtask

    // R10: shrink the period below the elapsed count
    task automatic t_shrink;
        wd_sel = 2'b00;
        step(45);
        chk("R10 long period still running", sys_rst, 1'b0);
        wd_sel = 2'b10;
        #1;
        chk("R10 not yet tripped", sys_rst, 1'b0);
        step(1);
        chk("R10 trip at next edge", sys_rst, 1'b1);
        wd_sel = 2'b11;
        step(REL);
        chk("R10 recovered", sys_rst, 1'b0);
    endtask

    // R1: reset during operation
    task automatic t_rst_mid;
        rst = 1'b1;
        step(1);
        chk("R1 mid-run reset", sys_rst, 1'b1);
        rst = 1'b0;
        step(REL - 1);
        chk("R1 R2 still held", sys_rst, 1'b1);
        step(1);
        chk("R2 release after mid-run reset", sys_rst, 1'b0);
    endtask

    initial begin
        t_powerup();
        t_brownout();
        t_glitch();
        t_timeout(2'b00, TLONG, 1'b1);
        t_timeout(2'b01, TMID, 1'b0);
        t_timeout(2'b10, TSHRT, 1'b1);
        t_kick();
        t_disabled();
        t_shrink();
        t_rst_mid();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule